// File: doc/BRIEF.md
# Transactional Commit Tracking Last-Level Cache

This block is a small non-volatile last-level cache that sits between the upper caches and persistent memory. Transactional line writes can arrive in any interleaving across transactions. Each resident line is marked either as settled (committed) or as owned by a transaction that is still open. Transactions are retired strictly in the order in which they were allocated. The cache therefore holds the new versions of open transactions next to the settled versions in memory, and it needs no log.

A producer first takes a transaction number from a small circular allocator. It then streams line writes tagged with that number. Two independent pulses mark the transaction: one says software asked for the commit, the other says the upper caches have delivered all of its lines. Once both are set for the oldest open transaction, a sequential scan settles that transaction's lines, one line per cycle. A one-cycle done pulse ends the scan.

A settled line may be displaced or overwritten. Before that happens, its content leaves on the write-back stream. A line owned by an open transaction is never displaced. When a write finds no line it may displace, it stalls and raises an overflow flag.

The write stream and the write-back stream both use valid/ready. The producer must hold `wr_valid` and the write fields stable until `wr_ready` is seen. `wb_valid` does not depend on `wb_ready`. Once `wb_valid` is raised, its address and data stay stable until `wb_ready` is high. The write that caused the write-back is accepted in the same cycle as the write-back handshake. `wr_ready` is only ever high while `wr_valid` is high.

Top module: `txn_commit_llc`

## Requirements
- R1: After reset no line is resident, `txn_alloc_id` is 0, `txn_alloc_full` is 0, and `wr_ready`, `wb_valid`, `overflow` and `commit_done` are all low.
- R2: Each accepted allocation request returns the current `txn_alloc_id` and advances it by one modulo NTXN. With NTXN transactions open, `txn_alloc_full` is high and a request neither changes `txn_alloc_id` nor opens a transaction.
- R3: A write that hits a line owned by the same open transaction overwrites that line in place without a write-back. A write that misses and finds an empty way fills it without a write-back.
- R4: The oldest open transaction is committed only after both its commit pulse and its delivered pulse have been seen. A younger transaction with both pulses waits until every older one has completed, and `commit_done_id` reports transactions in allocation order.
- R5: The commit scan starts in the cycle after both flags of the oldest transaction are set. It takes SETS*WAYS cycles, during which `wr_ready` stays low. `commit_done` is a single-cycle pulse in the cycle that follows the scan.
- R6: Committing keeps line data unchanged: a later write-back of a settled line carries the last value written to it.
- R7: A write that misses while every way of its set belongs to an open transaction raises `overflow`, keeps `wr_ready` low and issues no write-back.
- R8: A write that hits a settled line first sends that line's address and old data on the write-back stream. The line then takes the new data and becomes owned by the writing transaction.
- R9: The set index is the low log2(SETS) bits of the address and the tag is the remaining upper bits; write-back addresses are {tag, set}. On a miss the lowest-numbered empty way is chosen; failing that, the lowest-numbered settled way, whose content is written back first.
- R10: A write that hits a line owned by a different open transaction stalls without raising `overflow` until that transaction commits.
- R11: `wb_valid` with `wb_ready` low is followed by `wb_valid` with unchanged `wb_addr` and `wb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_alloc_req | input | 1 | Request a new transaction number |
| txn_alloc_id | output | TXW | Number handed out by the next allocation |
| txn_alloc_full | output | 1 | All NTXN numbers are open |
| wr_valid | input | 1 | Line write present |
| wr_ready | output | 1 | Line write accepted this cycle |
| wr_addr | input | ADDR_W | Line address |
| wr_txn | input | TXW | Owning transaction of the write |
| wr_data | input | DATA_W | Line data |
| commit_req | input | 1 | Commit pulse |
| commit_id | input | TXW | Transaction named by the commit pulse |
| drained_req | input | 1 | All-lines-delivered pulse |
| drained_id | input | TXW | Transaction named by the delivered pulse |
| commit_done | output | 1 | One-cycle pulse at the end of a commit scan |
| commit_done_id | output | TXW | Transaction just committed |
| wb_valid | output | 1 | Write-back to memory present |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_data | output | DATA_W | Write-back line data |
| overflow | output | 1 | Write stalled: no displaceable way in its set |

## Verification
Two interactions are the focus. In the first, a commit scan becomes due in the same cycle as a pending write. The bench drives write traffic while commit and delivered pulses land in random cycles, and a behavioural model compares every cycle. That comparison judges whether a write-back already offered keeps precedence and the scan waits one cycle, or whether the scan wins and the write is held off. In the second, a write is stalled on an open transaction's line, either as an overflow or as a conflicting hit. The stall is held across that transaction's commit, and the bench checks that the write then proceeds through a write-back of the freshly settled line.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;

  typedef struct packed {
    logic can_go;
    logic need_wb;
    logic no_room;
  } wr_plan_t;
endpackage

// File: rtl/tcc_txn_ctrl.sv
module tcc_txn_ctrl #(
  parameter int NTXN = 4,
  parameter int TXW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_req,
  input  logic           cmt_req,
  input  logic [TXW-1:0] cmt_id,
  input  logic           dlv_req,
  input  logic [TXW-1:0] dlv_id,
  input  logic           retire,
  output logic [TXW-1:0] tail_id,
  output logic           full,
  output logic [TXW-1:0] head_id,
  output logic           head_ready,
  output logic [TXW-1:0] done_id
);
  localparam logic [TXW:0] CNT_FULL = (TXW+1)'(NTXN);

  logic [TXW:0]    open_cnt;
  logic [NTXN-1:0] req_f, dlv_f;
  logic            take;

  assign full       = (open_cnt == CNT_FULL);
  assign take       = alloc_req && !full;
  assign head_ready = (open_cnt != '0) && req_f[head_id] && dlv_f[head_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_id  <= '0;
      head_id  <= '0;
      open_cnt <= '0;
      done_id  <= '0;
    end else begin
      if (take) tail_id <= tail_id + 1'b1;
      if (retire) begin
        head_id <= head_id + 1'b1;
        done_id <= head_id;
      end
      case ({take, retire})
        2'b10:   open_cnt <= open_cnt + 1'b1;
        2'b01:   open_cnt <= open_cnt - 1'b1;
        default: open_cnt <= open_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_f <= '0;
      dlv_f <= '0;
    end else begin
      for (int t = 0; t < NTXN; t++) begin
        if (retire && head_id == TXW'(t)) begin
          req_f[t] <= 1'b0;
          dlv_f[t] <= 1'b0;
        end else begin
          if (cmt_req && cmt_id == TXW'(t)) req_f[t] <= 1'b1;
          if (dlv_req && dlv_id == TXW'(t)) dlv_f[t] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcc_scan.sv
module tcc_scan
  import tcc_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          done
);
  localparam logic [IW-1:0] IDX_LAST = '1;

  scan_st_e st;

  assign busy = (st == SCAN_RUN);
  assign last = busy && (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SCAN_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      case (st)
        SCAN_IDLE: if (start) begin
          st  <= SCAN_RUN;
          idx <= '0;
        end
        SCAN_RUN: begin
          idx <= idx + 1'b1;
          if (last) st <= SCAN_IDLE;
        end
        default: st <= SCAN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcc_line_store.sv
module tcc_line_store #(
  parameter int WAYS   = 2,
  parameter int SW     = 2,
  parameter int WW     = 1,
  parameter int TAGW   = 4,
  parameter int DATA_W = 16,
  parameter int TXW    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [SW-1:0]                wset,
  input  logic [WW-1:0]                wway,
  input  logic [TAGW-1:0]              wtag,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [TXW-1:0]               wtxn,
  input  logic                         ce,
  input  logic [SW+WW-1:0]             cidx,
  input  logic [TXW-1:0]               cid,
  input  logic [SW-1:0]                rset,
  output logic [WAYS-1:0]              rd_val,
  output logic [WAYS-1:0]              rd_cmt,
  output logic [WAYS-1:0][TAGW-1:0]    rd_tag,
  output logic [WAYS-1:0][TXW-1:0]     rd_txn,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);
  localparam int IW    = SW + WW;
  localparam int LINES = 1 << IW;

  logic [LINES-1:0] lv, lc;
  logic [TAGW-1:0]   ltag [LINES];
  logic [TXW-1:0]    ltxn [LINES];
  logic [DATA_W-1:0] ldat [LINES];
  logic [IW-1:0]     widx;

  assign widx = {wset, wway};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv <= '0;
      lc <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (we && widx == IW'(i)) begin
          lv[i] <= 1'b1;
          lc[i] <= 1'b0;
        end else if (ce && cidx == IW'(i) && lv[i] && !lc[i] && ltxn[i] == cid) begin
          lc[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (we && widx == IW'(i)) begin
        ltag[i] <= wtag;
        ltxn[i] <= wtxn;
        ldat[i] <= wdata;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    logic [IW-1:0] ridx;
    assign ridx       = {rset, WW'(w)};
    assign rd_val[w]  = lv[ridx];
    assign rd_cmt[w]  = lc[ridx];
    assign rd_tag[w]  = ltag[ridx];
    assign rd_txn[w]  = ltxn[ridx];
    assign rd_data[w] = ldat[ridx];
  end
endmodule

// File: rtl/tcc_way_pick.sv
module tcc_way_pick #(
  parameter int WAYS = 2,
  parameter int WW   = 1,
  parameter int TAGW = 4
) (
  input  logic [WAYS-1:0]           rd_val,
  input  logic [WAYS-1:0]           rd_cmt,
  input  logic [WAYS-1:0][TAGW-1:0] rd_tag,
  input  logic [TAGW-1:0]           req_tag,
  output logic                      hit,
  output logic [WW-1:0]             hit_way,
  output logic                      room,
  output logic [WW-1:0]             room_way
);
  logic          empty_ok, settled_ok;
  logic [WW-1:0] empty_way, settled_way;

  always_comb begin
    hit         = 1'b0;
    hit_way     = '0;
    empty_ok    = 1'b0;
    empty_way   = '0;
    settled_ok  = 1'b0;
    settled_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rd_val[w] && rd_tag[w] == req_tag) begin
        hit     = 1'b1;
        hit_way = WW'(w);
      end
      if (!rd_val[w]) begin
        empty_ok  = 1'b1;
        empty_way = WW'(w);
      end
      if (rd_val[w] && rd_cmt[w]) begin
        settled_ok  = 1'b1;
        settled_way = WW'(w);
      end
    end
    room     = empty_ok || settled_ok;
    room_way = empty_ok ? empty_way : settled_way;
  end
endmodule

// File: rtl/txn_commit_llc.sv
module txn_commit_llc
  import tcc_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int NTXN   = 4,
  parameter int TXW    = $clog2(NTXN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_alloc_req,
  output logic [TXW-1:0]    txn_alloc_id,
  output logic              txn_alloc_full,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TXW-1:0]    wr_txn,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_req,
  input  logic [TXW-1:0]    commit_id,
  input  logic              drained_req,
  input  logic [TXW-1:0]    drained_id,
  output logic              commit_done,
  output logic [TXW-1:0]    commit_done_id,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              overflow
);
  localparam int SW   = $clog2(SETS);
  localparam int WW   = $clog2(WAYS);
  localparam int IW   = SW + WW;
  localparam int TAGW = ADDR_W - SW;

  logic [SW-1:0]               set_i;
  logic [TAGW-1:0]             tag_i;
  logic [WAYS-1:0]             rd_val, rd_cmt;
  logic [WAYS-1:0][TAGW-1:0]   rd_tag;
  logic [WAYS-1:0][TXW-1:0]    rd_txn;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  logic                        hit, room;
  logic [WW-1:0]               hit_way, room_way, sel_way;
  wr_plan_t                    plan;
  logic [ADDR_W-1:0]           vic_addr;
  logic [DATA_W-1:0]           vic_data;
  logic                        scan_busy, scan_last, scan_start, wr_open, wb_raw, wr_fire;
  logic [IW-1:0]               scan_idx;
  logic [TXW-1:0]              head_id;
  logic                        head_ready;

  assign set_i = wr_addr[SW-1:0];
  assign tag_i = wr_addr[ADDR_W-1:SW];

  tcc_txn_ctrl #(.NTXN(NTXN), .TXW(TXW)) u_txn (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(txn_alloc_req),
    .cmt_req(commit_req), .cmt_id(commit_id),
    .dlv_req(drained_req), .dlv_id(drained_id),
    .retire(scan_last),
    .tail_id(txn_alloc_id), .full(txn_alloc_full),
    .head_id(head_id), .head_ready(head_ready),
    .done_id(commit_done_id)
  );

  tcc_scan #(.IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .start(scan_start),
    .busy(scan_busy), .idx(scan_idx), .last(scan_last),
    .done(commit_done)
  );

  tcc_line_store #(
    .WAYS(WAYS), .SW(SW), .WW(WW), .TAGW(TAGW), .DATA_W(DATA_W), .TXW(TXW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .wset(set_i), .wway(sel_way), .wtag(tag_i),
    .wdata(wr_data), .wtxn(wr_txn),
    .ce(scan_busy), .cidx(scan_idx), .cid(head_id),
    .rset(set_i),
    .rd_val(rd_val), .rd_cmt(rd_cmt), .rd_tag(rd_tag),
    .rd_txn(rd_txn), .rd_data(rd_data)
  );

  tcc_way_pick #(.WAYS(WAYS), .WW(WW), .TAGW(TAGW)) u_pick (
    .rd_val(rd_val), .rd_cmt(rd_cmt), .rd_tag(rd_tag), .req_tag(tag_i),
    .hit(hit), .hit_way(hit_way), .room(room), .room_way(room_way)
  );

  // Decide what the presented write needs: in-place, write-back first, or wait.
  always_comb begin
    plan     = '0;
    sel_way  = '0;
    vic_addr = '0;
    vic_data = '0;
    if (hit) begin
      sel_way = hit_way;
      if (rd_cmt[hit_way]) begin
        plan.can_go  = 1'b1;
        plan.need_wb = 1'b1;
        vic_addr     = wr_addr;
        vic_data     = rd_data[hit_way];
      end else if (rd_txn[hit_way] == wr_txn) begin
        plan.can_go = 1'b1;
      end
    end else if (room) begin
      sel_way     = room_way;
      plan.can_go = 1'b1;
      if (rd_val[room_way]) begin
        plan.need_wb = 1'b1;
        vic_addr     = {rd_tag[room_way], set_i};
        vic_data     = rd_data[room_way];
      end
    end else begin
      plan.no_room = 1'b1;
    end
  end

  // An offered write-back keeps precedence over a commit scan becoming due.
  assign wb_raw     = wr_valid && !scan_busy && plan.need_wb;
  assign scan_start = head_ready && !scan_busy && !wb_raw;
  assign wr_open    = !scan_busy && !scan_start;
  assign wr_ready   = wr_valid && wr_open && plan.can_go && (!plan.need_wb || wb_ready);
  assign wr_fire    = wr_ready;
  assign wb_valid   = wb_raw;
  assign wb_addr    = vic_addr;
  assign wb_data    = vic_data;
  assign overflow   = wr_valid && wr_open && plan.no_room;
endmodule

// File: rtl/tcc_llc_chk.sv
module tcc_llc_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int TXW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_alloc_req,
  input logic              txn_alloc_full,
  input logic [TXW-1:0]    txn_alloc_id,
  input logic              wr_ready,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic              overflow,
  input logic              commit_done,
  input logic              scan_busy
);
  // R7
  overflow_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (!wr_ready && !wb_valid));

  // R11
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R2
  alloc_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_alloc_req && txn_alloc_full) |=> $stable(txn_alloc_id));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done);

  // R5
  scan_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !wr_ready);
endmodule

bind txn_commit_llc tcc_llc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TXW(TXW)) u_llc_chk (
  .clk(clk), .rst_n(rst_n),
  .txn_alloc_req(txn_alloc_req), .txn_alloc_full(txn_alloc_full), .txn_alloc_id(txn_alloc_id),
  .wr_ready(wr_ready), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .wb_data(wb_data), .overflow(overflow),
  .commit_done(commit_done), .scan_busy(scan_busy)
);

// File: tb/test_txn_commit_llc.sv
`timescale 1ns/1ps
module test_txn_commit_llc;
  localparam int SETS = 4, WAYS = 2, ADDR_W = 6, DATA_W = 16, NT = 4, TXW = 2;
  localparam int LINES = SETS * WAYS;

  logic clk = 0, rst_n = 0;
  logic txn_alloc_req = 0, txn_alloc_full;
  logic [TXW-1:0] txn_alloc_id;
  logic wr_valid = 0, wr_ready;
  logic [ADDR_W-1:0] wr_addr = 0;
  logic [TXW-1:0] wr_txn = 0;
  logic [DATA_W-1:0] wr_data = 0;
  logic commit_req = 0, drained_req = 0;
  logic [TXW-1:0] commit_id = 0, drained_id = 0;
  logic commit_done;
  logic [TXW-1:0] commit_done_id;
  logic wb_valid, wb_ready = 1, overflow;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  txn_commit_llc #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NTXN(NT)) i_txn_commit_llc (
    .clk(clk), .rst_n(rst_n),
    .txn_alloc_req(txn_alloc_req), .txn_alloc_id(txn_alloc_id), .txn_alloc_full(txn_alloc_full),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_txn(wr_txn), .wr_data(wr_data),
    .commit_req(commit_req), .commit_id(commit_id),
    .drained_req(drained_req), .drained_id(drained_id),
    .commit_done(commit_done), .commit_done_id(commit_done_id),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0, cmp_en = 0;

  task automatic check(string rq, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mv[SETS][WAYS], mc[SETS][WAYS];
  int mtag[SETS][WAYS], mt[SETS][WAYS], md[SETS][WAYS];
  int mhead, mtail, mcnt, mscnt, mdone_id;
  bit mreq[NT], mdlv[NT], mscan, mdone;

  task automatic model_reset();
    foreach (mv[s, w]) begin mv[s][w] = 0; mc[s][w] = 0; end
    foreach (mreq[t]) begin mreq[t] = 0; mdlv[t] = 0; end
    mhead = 0; mtail = 0; mcnt = 0; mscnt = 0; mdone_id = 0; mscan = 0; mdone = 0;
  endtask

  task automatic model_eval(output bit rdy, output bit wbv, output bit ovf, output bit start,
                            output int wba, output int wbd, output int way);
    int s, tg, hw, fw;
    bit p, need, can, over, open;
    s = int'(wr_addr) % SETS; tg = int'(wr_addr) / SETS; hw = -1; fw = -1;
    need = 0; can = 0; over = 0; wba = 0; wbd = 0; way = 0;
    p = !mscan && mcnt > 0 && mreq[mhead] && mdlv[mhead];
    for (int w = 0; w < WAYS; w++) if (hw < 0 && mv[s][w] && mtag[s][w] == tg) hw = w;
    if (hw >= 0) begin
      way = hw;
      if (mc[s][hw]) begin need = 1; can = 1; wba = int'(wr_addr); wbd = md[s][hw]; end
      else if (mt[s][hw] == int'(wr_txn)) can = 1;
    end else begin
      for (int w = 0; w < WAYS; w++) if (fw < 0 && !mv[s][w]) fw = w;
      for (int w = 0; w < WAYS; w++) if (fw < 0 && mc[s][w]) fw = w;
      if (fw < 0) over = 1;
      else begin
        way = fw; can = 1;
        if (mv[s][fw]) begin need = 1; wba = mtag[s][fw] * SETS + s; wbd = md[s][fw]; end
      end
    end
    wbv   = wr_valid && !mscan && need;
    start = p && !wbv;
    open  = !mscan && !start;
    rdy   = wr_valid && open && can && (!need || wb_ready);
    ovf   = wr_valid && open && over;
  endtask

  always @(posedge clk) begin
    bit rdy, wbv, ovf, start;
    int wba, wbd, way, oc, s;
    cyc++;
    if (!rst_n) model_reset();
    else begin
      model_eval(rdy, wbv, ovf, start, wba, wbd, way);
      oc = mcnt;
      mdone = 0;
      if (rdy) begin
        s = int'(wr_addr) % SETS;
        mv[s][way] = 1; mc[s][way] = 0; mtag[s][way] = int'(wr_addr) / SETS;
        mt[s][way] = int'(wr_txn); md[s][way] = int'(wr_data);
      end
      if (commit_req) mreq[commit_id] = 1;
      if (drained_req) mdlv[drained_id] = 1;
      if (txn_alloc_req && oc < NT) begin mtail = (mtail + 1) % NT; mcnt++; end
      if (mscan) begin
        if (mscnt == LINES - 1) begin
          foreach (mv[a, b]) if (mv[a][b] && !mc[a][b] && mt[a][b] == mhead) mc[a][b] = 1;
          mdone = 1; mdone_id = mhead;
          mreq[mhead] = 0; mdlv[mhead] = 0;
          mhead = (mhead + 1) % NT; mcnt--; mscan = 0;
        end else mscnt++;
      end else if (start) begin
        mscan = 1; mscnt = 0;
      end
    end
  end

  // ---------------- per-cycle comparison and monitor ----------------
  int wb_cnt = 0, last_wba = -1, last_wbd = -1;
  int done_q[$], done_cyc[$];

  always @(negedge clk) begin
    bit rdy, wbv, ovf, start;
    int wba, wbd, way;
    if (rst_n && cmp_en) begin
      model_eval(rdy, wbv, ovf, start, wba, wbd, way);
      check("R7 overflow", overflow, ovf);
      check("R8 R9 wb_valid", wb_valid, wbv);
      check("R3 R5 R10 wr_ready", wr_ready, rdy);
      if (wbv) begin
        check("R9 wb_addr", int'(wb_addr), wba);
        check("R6 R8 wb_data", int'(wb_data), wbd);
      end
      check("R5 commit_done", commit_done, mdone);
      if (mdone) check("R4 commit_done_id", int'(commit_done_id), mdone_id);
      check("R2 txn_alloc_id", int'(txn_alloc_id), mtail);
      check("R2 txn_alloc_full", txn_alloc_full, mcnt == NT);
    end
    if (rst_n) begin
      if (wb_valid && wb_ready) begin wb_cnt++; last_wba = int'(wb_addr); last_wbd = int'(wb_data); end
      if (commit_done) begin done_q.push_back(int'(commit_done_id)); done_cyc.push_back(cyc); end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(int a, int t, int d);
    int guard = 0;
    @(posedge clk) #1;
    wr_valid = 1; wr_addr = ADDR_W'(a); wr_txn = TXW'(t); wr_data = DATA_W'(d);
    forever begin
      @(negedge clk);
      if (wr_ready) break;
      guard++;
      if (guard > 400) begin check("R3 write accepted", 0, 1); break; end
    end
    @(posedge clk) #1 wr_valid = 0;
  endtask

  task automatic do_alloc();
    @(posedge clk) #1 txn_alloc_req = 1;
    @(posedge clk) #1 txn_alloc_req = 0;
  endtask

  task automatic pulse_commit(int t);
    @(posedge clk) #1 commit_req = 1; commit_id = TXW'(t);
    @(posedge clk) #1 commit_req = 0;
  endtask

  task automatic pulse_drained(int t, output int drive_cyc);
    @(posedge clk) #1 drained_req = 1; drained_id = TXW'(t); drive_cyc = cyc;
    @(posedge clk) #1 drained_req = 0;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  localparam int A1 = 16'h1111, A2 = 16'h2222, B1 = 16'h3333, C1 = 16'h4444;

  initial begin
    int k, base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 wr_ready", wr_ready, 0);
    check("R1 wb_valid", wb_valid, 0);
    check("R1 overflow", overflow, 0);
    check("R1 commit_done", commit_done, 0);
    check("R1 txn_alloc_id", int'(txn_alloc_id), 0);
    check("R1 txn_alloc_full", txn_alloc_full, 0);
    cmp_en = 1;

    do_alloc(); do_alloc();                 // T0, T1
    @(negedge clk) check("R2 id after two", int'(txn_alloc_id), 2);

    base = wb_cnt;
    do_write(4, 0, A1);                      // set0 way0
    do_write(8, 1, B1);                      // set0 way1
    do_write(4, 0, A2);                      // same-txn hit
    do_write(1, 0, C1);                      // set1 way0
    @(negedge clk) check("R3 no write-back for fills and same-txn hit", wb_cnt, base);

    // R7: set 0 full of open lines
    @(posedge clk) #1 wr_valid = 1; wr_addr = 12; wr_txn = 0; wr_data = 16'h5555;
    repeat (3) begin
      @(negedge clk);
      check("R7 overflow raised", overflow, 1);
      check("R7 write held", wr_ready, 0);
    end
    @(posedge clk) #1 wr_valid = 0;

    // R10: hit on a line of another open transaction
    @(posedge clk) #1 wr_valid = 1; wr_addr = 4; wr_txn = 1; wr_data = 16'h6666;
    repeat (3) begin
      @(negedge clk);
      check("R10 no overflow on conflict", overflow, 0);
      check("R10 conflict held", wr_ready, 0);
    end
    @(posedge clk) #1 wr_valid = 0;

    // R4: younger fully flagged, older only half
    pulse_commit(1); pulse_drained(1, k);
    pulse_commit(0);
    wait_cycles(20);
    check("R4 nothing committed early", done_q.size(), 0);
    pulse_drained(0, k);
    wait_cycles(3 * LINES + 6);
    check("R4 two commits", done_q.size(), 2);
    if (done_q.size() == 2) begin
      check("R4 first id", done_q[0], 0);
      check("R4 second id", done_q[1], 1);
      check("R5 first done cycle", done_cyc[0], k + 2 + LINES);
      check("R5 second done cycle", done_cyc[1], k + 3 + 2 * LINES);
    end

    // R8/R11/R6: new txn hits a settled line, memory back-pressures
    do_alloc();                              // T2
    base = wb_cnt;
    @(posedge clk) #1 wb_ready = 0; wr_valid = 1; wr_addr = 4; wr_txn = 2; wr_data = 16'h7777;
    repeat (3) begin
      @(negedge clk);
      check("R11 wb_valid held", wb_valid, 1);
      check("R8 wb_addr", int'(wb_addr), 4);
      check("R6 wb_data old version", int'(wb_data), A2);
      check("R11 write waits for wb", wr_ready, 0);
    end
    @(posedge clk) #1 wb_ready = 1;
    @(negedge clk) check("R11 write with wb handshake", wr_ready, 1);
    @(posedge clk) #1 wr_valid = 0;
    check("R8 one write-back", wb_cnt, base + 1);

    // R9: miss, settled way 1 displaced
    do_write(12, 2, 16'h8888);
    check("R9 victim addr", last_wba, 8);
    check("R9 victim data", last_wbd, B1);
    base = wb_cnt;
    do_write(5, 2, 16'h9999);                // set1: empty way preferred
    check("R9 empty way preferred", wb_cnt, base);

    // R2: fill the ring
    do_alloc(); do_alloc(); do_alloc();      // T3, T0, T1
    @(negedge clk);
    check("R2 full", txn_alloc_full, 1);
    check("R2 id wraps", int'(txn_alloc_id), 2);
    do_alloc();
    @(negedge clk);
    check("R2 full request ignored", int'(txn_alloc_id), 2);

    pulse_commit(2); pulse_drained(2, k);
    wait_cycles(LINES + 6);
    check("R4 third commit id", done_q.size() == 3 ? done_q[2] : -1, 2);

    // random traffic against the model
    for (int c = 0; c < 6000; c++) begin
      int wait_n;
      @(negedge clk);
      if (wr_valid && wr_ready) wr_valid_done = 1;
      @(posedge clk) #1;
      commit_req = 0; drained_req = 0; txn_alloc_req = 0;
      wb_ready = ($urandom % 4) != 0;
      if (wr_valid_done) begin wr_valid = 0; wr_valid_done = 0; wr_wait = 0; end
      else if (wr_valid) begin
        wr_wait++;
        if (wr_wait > 200 && !wb_valid) begin wr_valid = 0; wr_wait = 0; end
      end
      if (!wr_valid && mcnt > 0 && ($urandom % 2)) begin
        wait_n = $urandom % mcnt;
        wr_valid = 1; wr_addr = ADDR_W'($urandom); wr_data = DATA_W'($urandom);
        wr_txn = TXW'((mhead + wait_n) % NT);
      end
      if ($urandom % 8 == 0) begin commit_req = 1; commit_id = TXW'($urandom); end
      if ($urandom % 8 == 0) begin drained_req = 1; drained_id = TXW'($urandom); end
      if ($urandom % 6 == 0) txn_alloc_req = 1;
    end
    @(posedge clk) #1;
    wr_valid = 0; commit_req = 0; drained_req = 0; txn_alloc_req = 0;
    wait_cycles(4);
    finish_run();
  end

  bit wr_valid_done = 0;
  int wr_wait = 0;

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule